// File: doc/BRIEF.md
# Single-Wire Parity Byte Framer

This block frames and deframes bytes on a half-duplex single wire that idles high through a pull-up. The transmit half takes a byte over a valid/ready handshake. It drives a synchronisation pulse (low, then high), then the data bits most significant first, then an even-parity bit. It then holds the wire low for one more bit period and releases it. The receive half, while enabled, waits for the wire to fall and then for it to rise again. That rising edge sets its bit timing. It samples every bit at its midpoint, presents the rebuilt byte as a one-cycle strobe, and counts parity mismatches until the packet counter is cleared.

The surrounding logic owns transaction sequencing and bus turnaround. It grants the wire to the transmitter or enables the receiver, and it clears the mismatch counter at the start of each packet. A packet is good while the counter reads zero. The wire input is resynchronised before any sampling. All timing is set in system clock cycles: the bit period is `BIT_CYC`, and the falling-edge wait limit is `TO_BITS` bit periods.

Top module: `swire_link`

## Requirements
- R1: After reset the wire is released (`line_oe`=0), `tx_ready`=1, `rx_valid`=0, `rx_err_cnt`=0 and `rx_pkt_ok`=1.
- R2: On the cycle after a byte is accepted (`tx_valid` and `tx_ready` high at a clock edge), the wire is driven (`line_oe`=1) low for `BIT_CYC` cycles, then high for `BIT_CYC` cycles.
- R3: The data bits follow the sync pulse, most significant bit first, each held for `BIT_CYC` cycles.
- R4: After the data bits, a parity bit is driven for `BIT_CYC` cycles. Its value is the XOR of all data bits, so the ones count including parity is even.
- R5: After the parity bit, the wire is driven low for `BIT_CYC` cycles and then released. `tx_ready` is low from the cycle after acceptance until the release, and the release happens exactly 12·`BIT_CYC` cycles after acceptance for 8-bit data.
- R6: With `rx_en` high, the receiver takes the rising edge that follows a low level as its reference. It samples the data bits at bit midpoints and raises `rx_valid` for exactly one cycle with the byte on `rx_data`.
- R7: A received parity bit that differs from the XOR of the received data bits raises `rx_err_cnt` by one, saturating at 2^`CNT_W`−1. A matching parity bit leaves it unchanged. `rx_pkt_ok` is 1 exactly when the count is 0.
- R8: A high `rx_pkt_clr` sets `rx_err_cnt` to 0 on the next edge and takes priority over an increment.
- R9: If the wire does not fall within `TO_BITS`·`BIT_CYC` cycles after the receiver is armed, the receiver uses the high level as its reference at once. On an idle-high wire, `rx_valid` then appears `TO_BITS`·`BIT_CYC` + 1 + 1.5·`BIT_CYC` + 8·`BIT_CYC` edges after the first edge with `rx_en` high, carrying 0xFF and one parity mismatch.
- R10: While `rx_en` is low, traffic on the wire produces no `rx_valid` and leaves `rx_err_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Wire level as seen at the pad |
| line_o | output | 1 | Level to drive when `line_oe` is high |
| line_oe | output | 1 | Drive enable; low releases the wire to the pull-up |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | DATA_W | Byte to send |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| rx_en | input | 1 | Arms the receiver; low holds it idle |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DATA_W | Last received byte |
| rx_pkt_clr | input | 1 | Clears the parity mismatch counter |
| rx_err_cnt | output | CNT_W | Parity mismatches since the last clear |
| rx_pkt_ok | output | 1 | High while no mismatch has been counted |

## Verification
The hardest path to reach from the ports is the fall-wait timeout. A well-formed sender always pulls the wire low within one bit period, so the transmitter on its own never exercises the timeout. The bench arms the receiver on an idle-high wire and counts clock edges until the strobe. It checks that each timeout frame decodes as 0xFF with a mismatch, and keeps the receiver armed long enough that the counter reaches and holds its saturated value. Parity faults come from a bench-driven pulse sequence that flips only the parity bit, and this sequence takes over the wire whenever the transmitter has released it.

// File: rtl/swl_pkg.sv
package swl_pkg;
   typedef enum logic [2:0] {
      TX_IDLE, TX_SYNC_LO, TX_SYNC_HI, TX_DATA, TX_PAR, TX_TAIL
   } tx_state_e;

   typedef enum logic [2:0] {
      RX_OFF, RX_WAIT_LO, RX_WAIT_HI, RX_BITS, RX_GAP
   } rx_state_e;
endpackage

// File: rtl/swl_sync.sv
module swl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else begin
         ff[0] <= d;
         for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
      end
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/swl_tx.sv
module swl_tx
   import swl_pkg::*;
#(
   parameter int BIT_CYC = 16,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              line_o,
   output logic              line_oe
);
   localparam int CW = $clog2(BIT_CYC);
   localparam int IW = $clog2(DATA_W);
   localparam logic [CW-1:0] LD_BIT  = CW'(BIT_CYC - 1);
   localparam logic [IW-1:0] LAST_IX = IW'(DATA_W - 1);

   tx_state_e         state;
   logic [CW-1:0]     tmr;
   logic [DATA_W-1:0] sh;
   logic [IW-1:0]     idx;
   logic              par;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         tmr   <= '0;
         sh    <= '0;
         idx   <= '0;
         par   <= 1'b0;
      end else if (state == TX_IDLE) begin
         if (tx_valid) begin
            state <= TX_SYNC_LO;
            tmr   <= LD_BIT;
            sh    <= tx_data;
            idx   <= '0;
            par   <= ^tx_data;
         end
      end else if (tmr != '0) begin
         tmr <= tmr - 1'b1;
      end else begin
         tmr <= LD_BIT;
         unique case (state)
            TX_SYNC_LO: state <= TX_SYNC_HI;
            TX_SYNC_HI: state <= TX_DATA;
            TX_DATA: begin
               sh  <= sh << 1;
               idx <= idx + 1'b1;
               if (idx == LAST_IX) state <= TX_PAR;
            end
            TX_PAR:  state <= TX_TAIL;
            default: state <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state)
         TX_SYNC_LO: line_o = 1'b0;
         TX_SYNC_HI: line_o = 1'b1;
         TX_DATA:    line_o = sh[DATA_W-1];
         TX_PAR:     line_o = par;
         TX_TAIL:    line_o = 1'b0;
         default:    line_o = 1'b1;
      endcase
   end

   assign tx_ready = (state == TX_IDLE);
   assign line_oe  = (state != TX_IDLE);

   // R2
   sync_low_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> line_oe && !line_o);

   // R5
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !tx_ready);

   // R5
   release_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_oe) |-> !$past(line_o));
endmodule

// File: rtl/swl_rx.sv
module swl_rx
   import swl_pkg::*;
#(
   parameter int BIT_CYC = 16,
   parameter int DATA_W  = 8,
   parameter int TO_BITS = 5,
   parameter int CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_s,
   input  logic              rx_en,
   input  logic              pkt_clr,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic [CNT_W-1:0]  err_cnt
);
   localparam int FIRST  = BIT_CYC + BIT_CYC / 2;
   localparam int GAP    = BIT_CYC - BIT_CYC / 2;
   localparam int TO_CYC = TO_BITS * BIT_CYC;
   localparam int CW     = $clog2(FIRST);
   localparam int TW     = $clog2(TO_CYC);
   localparam int IW     = $clog2(DATA_W + 1);
   localparam logic [CW-1:0]    LD_FIRST = CW'(FIRST - 1);
   localparam logic [CW-1:0]    LD_BIT   = CW'(BIT_CYC - 1);
   localparam logic [CW-1:0]    LD_GAP   = CW'(GAP - 1);
   localparam logic [TW-1:0]    LD_TO    = TW'(TO_CYC - 1);
   localparam logic [IW-1:0]    PAR_IX   = IW'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   rx_state_e         state;
   logic [CW-1:0]     tmr;
   logic [TW-1:0]     tocnt;
   logic [DATA_W-1:0] sh;
   logic [IW-1:0]     idx;
   logic              par_acc;
   logic              par_slot, bad_evt;

   assign par_slot = rx_en && (state == RX_BITS) && (tmr == '0) && (idx == PAR_IX);
   assign bad_evt  = par_slot && (par_acc != line_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_OFF;
         tmr      <= '0;
         tocnt    <= '0;
         sh       <= '0;
         idx      <= '0;
         par_acc  <= 1'b0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (!rx_en) begin
            state <= RX_OFF;
         end else begin
            unique case (state)
               RX_OFF: begin
                  state <= RX_WAIT_LO;
                  tocnt <= LD_TO;
               end
               RX_WAIT_LO: begin
                  if (!line_s || tocnt == '0) state <= RX_WAIT_HI;
                  else tocnt <= tocnt - 1'b1;
               end
               RX_WAIT_HI: begin
                  if (line_s) begin
                     state   <= RX_BITS;
                     tmr     <= LD_FIRST;
                     idx     <= '0;
                     sh      <= '0;
                     par_acc <= 1'b0;
                  end
               end
               RX_BITS: begin
                  if (tmr != '0) begin
                     tmr <= tmr - 1'b1;
                  end else if (idx == PAR_IX) begin
                     rx_valid <= 1'b1;
                     rx_data  <= sh;
                     state    <= RX_GAP;
                     tmr      <= LD_GAP;
                  end else begin
                     sh      <= {sh[DATA_W-2:0], line_s};
                     par_acc <= par_acc ^ line_s;
                     idx     <= idx + 1'b1;
                     tmr     <= LD_BIT;
                  end
               end
               default: begin
                  if (tmr != '0) tmr <= tmr - 1'b1;
                  else begin
                     state <= RX_WAIT_LO;
                     tocnt <= LD_TO;
                  end
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            err_cnt <= '0;
      else if (pkt_clr)                      err_cnt <= '0;
      else if (bad_evt && err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
   end

   // R6
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R10
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_valid);

   // R7
   count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_clr |=> err_cnt >= $past(err_cnt));

   // R8
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_clr |=> err_cnt == '0);
endmodule

// File: rtl/swire_link.sv
module swire_link #(
   parameter int BIT_CYC     = 16,
   parameter int DATA_W      = 8,
   parameter int TO_BITS     = 5,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   output logic              line_o,
   output logic              line_oe,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   input  logic              rx_en,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   input  logic              rx_pkt_clr,
   output logic [CNT_W-1:0]  rx_err_cnt,
   output logic              rx_pkt_ok
);
   if (BIT_CYC < 8) begin : g_bad_bit
      $error("BIT_CYC must be at least 8");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (TO_BITS < 1) begin : g_bad_to
      $error("TO_BITS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic line_s;

   swl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_i), .q(line_s)
   );

   swl_tx #(.BIT_CYC(BIT_CYC), .DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .line_o(line_o), .line_oe(line_oe)
   );

   swl_rx #(.BIT_CYC(BIT_CYC), .DATA_W(DATA_W), .TO_BITS(TO_BITS), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .line_s(line_s),
      .rx_en(rx_en), .pkt_clr(rx_pkt_clr),
      .rx_valid(rx_valid), .rx_data(rx_data), .err_cnt(rx_err_cnt)
   );

   assign rx_pkt_ok = (rx_err_cnt == '0);
endmodule

// File: tb/swire_link_test.sv
module swire_link_test;
   localparam int BIT = 16;
   localparam int DW  = 8;
   localparam int TOB = 5;
   localparam int CW  = 4;
   localparam int TOC = TOB * BIT;
   localparam int K_TO = TOC + 1 + BIT + BIT / 2 + DW * BIT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_valid = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic rx_en = 1'b0;
   logic rx_pkt_clr = 1'b0;
   logic bb_line = 1'b1;
   logic line_o, line_oe, tx_ready, rx_valid, rx_pkt_ok;
   logic [DW-1:0] rx_data;
   logic [CW-1:0] rx_err_cnt;
   logic line_w;

   int nchk = 0;
   int nfail = 0;
   int got_cnt = 0;
   logic [DW-1:0] got_data = '0;

   always #2 clk = ~clk;

   assign line_w = line_oe ? line_o : bb_line;

   swire_link #(.BIT_CYC(BIT), .DATA_W(DW), .TO_BITS(TOB), .SYNC_STAGES(2), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .line_i(line_w), .line_o(line_o), .line_oe(line_oe),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_en(rx_en), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_pkt_clr(rx_pkt_clr), .rx_err_cnt(rx_err_cnt), .rx_pkt_ok(rx_pkt_ok)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         got_cnt  <= got_cnt + 1;
         got_data <= rx_data;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_tx_idle();
      for (int w = 0; w < 20 * BIT && !tx_ready; w++) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(line_oe == 1'b0, "R1 wire released", int'(line_oe), 0);
      chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
      chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
      chk(rx_err_cnt == '0, "R1 err count", int'(rx_err_cnt), 0);
      chk(rx_pkt_ok == 1'b1, "R1 pkt ok", int'(rx_pkt_ok), 1);
   endtask

   task automatic t_tx_wave(input logic [DW-1:0] d);
      @(negedge clk);
      tx_data = d; tx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      chk(!tx_ready, "R5 ready low when busy", int'(tx_ready), 0);
      repeat (BIT / 2) @(posedge clk);
      @(negedge clk);
      chk(line_oe && !line_o, "R2 sync low", int'({line_oe, line_o}), 2);
      repeat (BIT) @(negedge clk);
      chk(line_oe && line_o, "R2 sync high", int'({line_oe, line_o}), 3);
      for (int k = 0; k < DW; k++) begin
         repeat (BIT) @(negedge clk);
         chk(line_oe && line_o == d[DW-1-k], "R3 data bit msb first", int'(line_o), int'(d[DW-1-k]));
      end
      repeat (BIT) @(negedge clk);
      chk(line_oe && line_o == ^d, "R4 even parity bit", int'(line_o), int'(^d));
      repeat (BIT) @(negedge clk);
      chk(line_oe && !line_o, "R5 tail low", int'({line_oe, line_o}), 2);
      repeat (BIT / 2 - 1) @(negedge clk);
      chk(!tx_ready && line_oe, "R5 busy until release", int'(tx_ready), 0);
      @(negedge clk);
      chk(tx_ready && !line_oe, "R5 released after tail", int'({tx_ready, line_oe}), 2);
   endtask

   task automatic t_loop(input logic [DW-1:0] d);
      int base;
      logic [CW-1:0] e0;
      @(negedge clk);
      rx_en = 1'b1;
      base = got_cnt;
      e0 = rx_err_cnt;
      tx_data = d; tx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      for (int w = 0; w < 20 * BIT && got_cnt == base; w++) @(negedge clk);
      chk(got_cnt == base + 1, "R6 byte strobed", got_cnt - base, 1);
      chk(got_data == d, "R6 byte value", int'(got_data), int'(d));
      chk(rx_err_cnt == e0, "R7 good parity no count", int'(rx_err_cnt), int'(e0));
      @(negedge clk);
      chk(!rx_valid, "R6 strobe one cycle", int'(rx_valid), 0);
      rx_en = 1'b0;
      wait_tx_idle();
   endtask

   task automatic t_ignore(input logic [DW-1:0] d);
      int base;
      logic [CW-1:0] e0;
      @(negedge clk);
      rx_en = 1'b0;
      base = got_cnt;
      e0 = rx_err_cnt;
      tx_data = d; tx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      wait_tx_idle();
      repeat (2 * BIT) @(negedge clk);
      chk(got_cnt == base, "R10 no strobe while disabled", got_cnt - base, 0);
      chk(rx_err_cnt == e0, "R10 count untouched", int'(rx_err_cnt), int'(e0));
   endtask

   task automatic t_bb(input logic [DW-1:0] d, input logic flip, input int exp_err);
      int base;
      @(negedge clk);
      rx_en = 1'b1;
      base = got_cnt;
      @(negedge clk);
      bb_line = 1'b0;
      repeat (BIT) @(negedge clk);
      bb_line = 1'b1;
      repeat (BIT) @(negedge clk);
      for (int k = DW - 1; k >= 0; k--) begin
         bb_line = d[k];
         repeat (BIT) @(negedge clk);
      end
      bb_line = (^d) ^ flip;
      repeat (BIT) @(negedge clk);
      bb_line = 1'b0;
      repeat (BIT) @(negedge clk);
      rx_en = 1'b0;
      @(negedge clk);
      bb_line = 1'b1;
      repeat (4) @(negedge clk);
      chk(got_cnt == base + 1, "R6 injected byte strobed", got_cnt - base, 1);
      chk(got_data == d, "R6 injected byte value", int'(got_data), int'(d));
      chk(int'(rx_err_cnt) == exp_err, "R7 mismatch count", int'(rx_err_cnt), exp_err);
      chk(rx_pkt_ok == (exp_err == 0), "R7 pkt ok flag", int'(rx_pkt_ok), int'(exp_err == 0));
   endtask

   task automatic t_clear();
      @(negedge clk);
      rx_pkt_clr = 1'b1;
      @(negedge clk);
      rx_pkt_clr = 1'b0;
      chk(rx_err_cnt == '0, "R8 count cleared", int'(rx_err_cnt), 0);
      chk(rx_pkt_ok, "R8 pkt ok after clear", int'(rx_pkt_ok), 1);
   endtask

   task automatic t_timeout();
      int n;
      @(negedge clk);
      rx_en = 1'b1;
      n = 0;
      while (!rx_valid && n < K_TO + 4 * BIT) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      chk(n >= K_TO && n <= K_TO + 2, "R9 timeout frame timing", n, K_TO + 1);
      chk(rx_data == '1, "R9 idle frame value", int'(rx_data), 255);
      chk(rx_err_cnt == 1, "R9 idle frame mismatch", int'(rx_err_cnt), 1);
      for (int f = 2; f <= 16; f++) begin
         @(negedge clk);
         for (int w = 0; w < K_TO + 4 * BIT && !rx_valid; w++) @(negedge clk);
         if (f == 15) chk(rx_err_cnt == '1, "R7 count reaches max", int'(rx_err_cnt), 15);
      end
      @(negedge clk);
      chk(rx_err_cnt == '1, "R7 count saturates", int'(rx_err_cnt), 15);
      chk(!rx_pkt_ok, "R7 pkt flagged bad", int'(rx_pkt_ok), 0);
      rx_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx_wave(8'hA5);
      t_tx_wave(8'h01);
      t_loop(8'h3C);
      t_loop(8'hC3);
      t_loop(8'h80);
      t_ignore(8'h5A);
      t_bb(8'h96, 1'b0, 0);
      t_bb(8'h96, 1'b1, 1);
      t_bb(8'h4E, 1'b0, 1);
      t_clear();
      t_timeout();
      t_clear();
      t_loop(8'h7F);
      finish_run();
   end
endmodule